// File: doc/BRIEF.md
# SPI Master Word Engine with Automatic Select

This block is the shift engine of a serial peripheral bus master. Each accepted start strobe moves one word out on the data-out line and, at the same time, collects one word from the data-in line. Every clock cycle on the serial clock carries one bit. The word is either 8 or 16 bits long, and it goes out most significant bit first or least significant bit first. The serial clock has a selectable idle level and a selectable phase. Its rate comes from a 16-bit divider value: one half period of the serial clock lasts `max(div_val,1)+1` system clocks.

The active-low select output works in one of two ways. In phase 0 the engine drives it alone: it goes low when the word starts and goes high after the last clock edge. It then stays high for one full bit time, and the engine accepts no new start during that time. In phase 1 the select output copies a software flag, so software decides whether the select stays low across consecutive words. Configuration, divider and transmit word are captured when a start is accepted. At the end the received word appears on a parallel output together with a one-cycle done pulse.

Top module: `spi_xfer_master`

## Requirements
- R1: With `cfg_cpha`=0, `ss_n` goes low in the cycle after an accepted start and stays low until the 2N-th serial clock edge (N = word bits). It then stays high for 2H cycles (H = half period), during which `busy` stays 1. `busy` falls 2H cycles after the final edge. `sel_flag` has no effect in this mode.
- R2: With `cfg_cpha`=1, `ss_n` equals the inverse of `sel_flag` one system clock later, whether or not a word is moving, and the engine never changes it on its own.
- R3: With `cfg_cpha`=0, the first data bit is on `mosi` in the cycle after the start is accepted, and the first `sck` edge comes H cycles after the start in both phases.
- R4: `sck` rests at `cfg_cpol` (0 = low, 1 = high) when idle, makes exactly 2N transitions per word, and is back at that level when `busy` falls.
- R5: In phase 0, `miso` is sampled on leading (odd-numbered) edges and `mosi` changes on trailing edges. In phase 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R6: With `cfg_lsb_first`=0 the first bit on the wire is bit N-1 of the word. With `cfg_lsb_first`=1 it is bit 0. Received bits are assembled with the same order.
- R7: `cfg_wide`=0 gives N=8, which sends `tx_word[7:0]` and returns the received byte in `rx_word[7:0]` with the upper bits zero. `cfg_wide`=1 gives N=16.
- R8: `done` is high for exactly one cycle per word. It rises in the cycle after the last sample edge, which is edge 2N-1 in phase 0 and edge 2N in phase 1, and `rx_word` holds the new word in that same cycle.
- R9: A `start` while `busy` is 1, including during the phase-0 select gap, is ignored: it does not change the word in flight, the timing, or the number of `done` pulses.
- R10: Successive `sck` edges are exactly H = max(`div_val`,1)+1 system clocks apart, so a divider of 0 behaves as 1.
- R11: After a word, `mosi` keeps the last bit it sent until the next word drives a new bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe; accepted only when idle |
| tx_word | input | 16 | Word to send |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_wide | input | 1 | 0 = 8-bit word, 1 = 16-bit word |
| div_val | input | 16 | Half-period divider value |
| sel_flag | input | 1 | Software select request used in phase 1 |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low slave select |
| rx_word | output | 16 | Last received word |
| done | output | 1 | One-cycle end-of-word pulse |
| busy | output | 1 | Word or select gap in progress |

## Verification
The bench models a slave that shifts its own word out and records `mosi` on the edges the mode defines. This exposes a phase mix-up, such as sampling on the wrong edge or driving the first bit late in phase 0, as a corrupted word on one side or both. It measures the cycle of the first edge, the spacing of edges, and the cycles of the done pulse and of the fall of `busy`. A divider that is off by one, or that does not clamp zero, therefore shows up as shifted times, and a design that skips the phase-0 select gap shows up as `busy` falling early. Starts issued in the middle of a word and inside the select gap catch an engine that restarts or double-pulses `done`. Byte mode combined with least-significant-first catches a received byte left in the upper half of `rx_word`.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } xfer_st_e;

  // Divider value with zero clamped to one (half period = result + 1).
  function automatic logic [31:0] eff_div(input logic [31:0] d);
    return (d == 32'd0) ? 32'd1 : d;
  endfunction

  // Bits in one word for the selected size.
  function automatic int unsigned word_bits(input logic wide,
                                            input int unsigned short_w,
                                            input int unsigned long_w);
    return wide ? long_w : short_w;
  endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R10: the limit is never below one, so two ticks never touch
  a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/spi_word_shift.sv
module spi_word_shift #(
  parameter int W       = 16,
  parameter int SHORT_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         lsb,
  input  logic         wide,
  input  logic [W-1:0] tx,
  input  logic         drive,
  input  logic         sample,
  input  logic         capture,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  localparam int PAD = W - SHORT_W;

  logic         lsb_q, wide_q;
  logic [W-1:0] tx_sh, rx_sh;
  logic         lsb_sel;
  logic [W-1:0] aligned, src, rx_next, rx_final;

  assign lsb_sel  = load ? lsb : lsb_q;
  assign aligned  = (lsb || wide) ? tx : (tx << PAD);
  assign src      = load ? aligned : tx_sh;
  assign rx_next  = lsb_q ? {miso, rx_sh[W-1:1]} : {rx_sh[W-2:0], miso};
  assign rx_final = (lsb_q && !wide_q) ? (rx_next >> PAD) : rx_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_q   <= 1'b0;
      wide_q  <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      mosi    <= 1'b0;
      rx_word <= '0;
    end else begin
      if (load) begin
        lsb_q  <= lsb;
        wide_q <= wide;
        rx_sh  <= '0;
      end
      if (drive) begin
        mosi  <= lsb_sel ? src[0] : src[W-1];
        tx_sh <= lsb_sel ? (src >> 1) : (src << 1);
      end else if (load) begin
        tx_sh <= aligned;
      end
      if (sample)  rx_sh   <= rx_next;
      if (capture) rx_word <= rx_final;
    end
  end

  // R8: the word is only latched on a sampling edge
  a_r8_capture_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> sample);

  // R11: data out moves only on a drive event
  a_r11_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |=> $stable(mosi));

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHORT_W = 8,
  parameter int DIV_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              cfg_wide,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              sel_flag,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic [DATA_W-1:0] rx_word,
  output logic              done,
  output logic              busy
);
  localparam int CNT_W = $clog2(2 * DATA_W + 1);

  xfer_st_e         state;
  logic             cpol_q, cpha_q, wide_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] edge_cnt;
  logic [CNT_W-1:0] two_n;

  // Named internal events
  logic tick, accept, lead_edge, last_edge, last_sample;
  logic sample_ev, drive_ev, capture_ev, run_tick;

  assign two_n       = CNT_W'(2 * word_bits(wide_q, SHORT_W, DATA_W));
  assign accept      = start && (state == ST_IDLE);
  assign run_tick    = (state == ST_RUN) && tick;
  assign lead_edge   = !edge_cnt[0];
  assign last_edge   = (edge_cnt == two_n - 1'b1);
  assign last_sample = (edge_cnt == (cpha_q ? two_n - 1'b1 : two_n - 2'd2));
  assign sample_ev   = run_tick && (cpha_q ? !lead_edge : lead_edge);
  assign drive_ev    = (accept && !cfg_cpha) ||
                       (run_tick && (cpha_q ? lead_edge : (!lead_edge && !last_edge)));
  assign capture_ev  = sample_ev && last_sample;
  assign busy        = (state != ST_IDLE);

  spi_half_tick #(.DIV_W(DIV_W)) tick_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .limit (div_q),
    .tick  (tick)
  );

  spi_word_shift #(.W(DATA_W), .SHORT_W(SHORT_W)) shift_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .lsb     (cfg_lsb_first),
    .wide    (cfg_wide),
    .tx      (tx_word),
    .drive   (drive_ev),
    .sample  (sample_ev),
    .capture (capture_ev),
    .miso    (miso),
    .mosi    (mosi),
    .rx_word (rx_word)
  );

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      wide_q   <= 1'b0;
      div_q    <= DIV_W'(1);
      edge_cnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= capture_ev;
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_RUN;
          cpol_q   <= cfg_cpol;
          cpha_q   <= cfg_cpha;
          wide_q   <= cfg_wide;
          div_q    <= DIV_W'(eff_div(32'(div_val)));
          edge_cnt <= '0;
        end
        ST_RUN: if (tick) begin
          if (last_edge) begin
            edge_cnt <= '0;
            state    <= cpha_q ? ST_IDLE : ST_GAP;
          end else begin
            edge_cnt <= edge_cnt + 1'b1;
          end
        end
        ST_GAP: if (tick) begin
          if (edge_cnt == CNT_W'(1)) begin
            edge_cnt <= '0;
            state    <= ST_IDLE;
          end else begin
            edge_cnt <= edge_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Serial clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             sck <= 1'b0;
    else if (state == ST_IDLE) sck <= cfg_cpol;
    else if (run_tick)      sck <= ~sck;
  end

  // Slave select
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_n <= 1'b1;
    end else if (accept && !cfg_cpha) begin
      ss_n <= 1'b0;
    end else if (state == ST_RUN && !cpha_q) begin
      if (run_tick && last_edge) ss_n <= 1'b1;
    end else if ((state == ST_IDLE) ? cfg_cpha : cpha_q) begin
      ss_n <= ~sel_flag;
    end else begin
      ss_n <= 1'b1;
    end
  end

  // R1: select held low for the whole phase-0 word
  a_r1_ss_low_in_word: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !cpha_q) |-> !ss_n);

  // R1: select high throughout the inter-word gap
  a_r1_gap_ss_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> ss_n);

  // R2: phase-1 select tracks the software flag one cycle later
  a_r2_flag_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && cpha_q) |-> (ss_n == !$past(sel_flag)));

  // R4: serial clock back at idle level when the engine goes idle
  a_r4_idle_sck: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sck == cpol_q));

  // R7: edge counter never passes the word length
  a_r7_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (edge_cnt < two_n));

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: captured mode is frozen while a word is active
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |=> ($stable(cpha_q) && $stable(wide_q) && $stable(div_q)));

endmodule

// File: tb/spi_xfer_master_tb_top.sv
module spi_xfer_master_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_wide, sel_flag, miso;
  logic [15:0] tx_word, div_val, rx_word;
  logic        sck, mosi, ss_n, done, busy;

  int errors = 0;
  int checks = 0;

  spi_xfer_master dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .cfg_wide(cfg_wide), .div_val(div_val), .sel_flag(sel_flag), .miso(miso),
    .sck(sck), .mosi(mosi), .ss_n(ss_n), .rx_word(rx_word), .done(done), .busy(busy)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  bit          sl_active = 0;
  bit          sl_cpol, sl_cpha, sl_lsb;
  int          sl_n, sl_lead, sl_trail;
  logic [15:0] sl_word, sl_got;

  function automatic logic slave_bit(input int i);
    if (i >= sl_n) return 1'b0;
    return sl_lsb ? sl_word[i] : sl_word[sl_n-1-i];
  endfunction

  task automatic slave_store(input int idx);
    if (idx < sl_n) begin
      if (sl_lsb) sl_got[idx] = mosi;
      else        sl_got[sl_n-1-idx] = mosi;
    end
  endtask

  always @(sck) begin
    if (sl_active) begin
      if (sck != sl_cpol) begin
        sl_lead++;
        if (!sl_cpha) slave_store(sl_lead - 1);
        else          miso = slave_bit(sl_lead - 1);
      end else begin
        sl_trail++;
        if (!sl_cpha) begin
          if (sl_trail < sl_n) miso = slave_bit(sl_trail);
        end else begin
          slave_store(sl_trail - 1);
        end
      end
    end
  end

  // ---------------- generic transfer ----------------
  task automatic run_xfer(input string name, input bit cpol, input bit cpha,
                          input bit lsb, input bit wide, input int div,
                          input logic [15:0] tx, input logic [15:0] sw,
                          input int extra_j);
    int n, h, j, edges, first_edge, spacing_bad, done_cnt, done_j, ss_bad, fall_j;
    logic [15:0] mask, rx_at_done;
    logic prev_sck, last_bit;
    n    = wide ? 16 : 8;
    h    = ((div == 0) ? 1 : div) + 1;
    mask = wide ? 16'hFFFF : 16'h00FF;
    @(negedge clk);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb; cfg_wide = wide;
    div_val = 16'(div); tx_word = tx;
    sl_cpol = cpol; sl_cpha = cpha; sl_lsb = lsb; sl_n = n; sl_word = sw;
    sl_lead = 0; sl_trail = 0; sl_got = '0;
    miso = cpha ? 1'b0 : slave_bit(0);
    @(negedge clk);
    check(sck == cpol, "R4", {name, " idle sck"}, sck, cpol);
    sl_active = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9", {name, " busy after start"}, busy, 1);
    if (!cpha) begin
      check(ss_n == 1'b0, "R1", {name, " select low at start"}, ss_n, 0);
      last_bit = lsb ? tx[0] : tx[n-1];
      check(mosi == last_bit, "R3", {name, " first bit early"}, mosi, last_bit);
    end
    j = 0; edges = 0; first_edge = -1; spacing_bad = 0; done_cnt = 0;
    done_j = -1; ss_bad = 0; fall_j = -1; prev_sck = sck; rx_at_done = '0;
    while (j < 5000) begin
      if (extra_j > 0 && j == extra_j) begin
        start = 1'b1; tx_word = ~tx;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      j++;
      if (sck != prev_sck) begin
        edges++;
        if (first_edge < 0) first_edge = j;
        if (j != edges * h) spacing_bad++;
      end
      prev_sck = sck;
      if (done) begin
        done_cnt++; done_j = j; rx_at_done = rx_word;
      end
      if (!cpha) begin
        if (ss_n != ((j < 2*n*h) ? 1'b0 : 1'b1)) ss_bad++;
      end else begin
        if (ss_n != !sel_flag) ss_bad++;
      end
      if (!busy) begin
        fall_j = j;
        break;
      end
    end
    start = 1'b0;
    sl_active = 0;
    check(first_edge == h, "R3", {name, " first edge cycle"}, first_edge, h);
    check(spacing_bad == 0, "R10", {name, " edge spacing"}, spacing_bad, 0);
    check(edges == 2*n, "R4", {name, " edge count"}, edges, 2*n);
    check(sck == cpol, "R4", {name, " sck idle after"}, sck, cpol);
    check(done_cnt == 1, "R9", {name, " single done"}, done_cnt, 1);
    check(done_j == (cpha ? 2*n*h : (2*n-1)*h), "R8", {name, " done cycle"},
          done_j, cpha ? 2*n*h : (2*n-1)*h);
    check(rx_at_done == (sw & mask), "R6", {name, " received word"},
          rx_at_done, sw & mask);
    check((sl_got & mask) == (tx & mask), "R5", {name, " slave saw word"},
          sl_got & mask, tx & mask);
    check(ss_bad == 0, cpha ? "R2" : "R1", {name, " select waveform"}, ss_bad, 0);
    check(fall_j == (cpha ? 2*n*h : (2*n+2)*h), "R1", {name, " busy fall"},
          fall_j, cpha ? 2*n*h : (2*n+2)*h);
    last_bit = lsb ? tx[n-1] : tx[0];
    repeat (4) @(negedge clk);
    check(mosi == last_bit, "R11", {name, " mosi holds"}, mosi, last_bit);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    check(sck == 1'b0, "R4", "reset sck", sck, 0);
    check(ss_n == 1'b1, "R1", "reset select", ss_n, 1);
    check(busy == 1'b0 && done == 1'b0, "R8", "reset busy/done", {busy, done}, 0);
    check(rx_word == 16'h0, "R7", "reset rx", rx_word, 0);
  endtask

  task automatic t_mode0_byte_msb;
    sel_flag = 1'b0;
    run_xfer("m0 byte msb", 1'b0, 1'b0, 1'b0, 1'b0, 1, 16'hFFA5, 16'h123C, 0);
  endtask

  task automatic t_mode0_word_lsb_cpol1;
    sel_flag = 1'b1; // ignored in phase 0 (R1)
    run_xfer("m0 word lsb cpol1", 1'b1, 1'b0, 1'b1, 1'b1, 3, 16'h1234, 16'hBEEF, 0);
  endtask

  task automatic t_mode1_back_to_back;
    sel_flag = 1'b1;
    run_xfer("m1 word msb a", 1'b0, 1'b1, 1'b0, 1'b1, 2, 16'hC3A1, 16'h5A0F, 0);
    check(ss_n == 1'b0, "R2", "select held low between words", ss_n, 0);
    run_xfer("m1 word msb b restart", 1'b0, 1'b1, 1'b0, 1'b1, 2, 16'h0F81, 16'h9C35, 4);
    check(ss_n == 1'b0, "R2", "select still low after b", ss_n, 0);
  endtask

  task automatic t_mode1_byte_lsb_div0;
    sel_flag = 1'b0;
    run_xfer("m1 byte lsb div0", 1'b1, 1'b1, 1'b1, 1'b0, 0, 16'hAB6D, 16'h77C1, 0);
    check(rx_word[15:8] == 8'h00, "R7", "byte rx upper zero", rx_word[15:8], 0);
  endtask

  task automatic t_mode0_gap_start;
    sel_flag = 1'b0;
    run_xfer("m0 gap start", 1'b0, 1'b0, 1'b0, 1'b0, 1, 16'h0096, 16'h00E4, 2*8*2 + 1);
  endtask

  task automatic t_flag_follow;
    @(negedge clk);
    cfg_cpha = 1'b1; sel_flag = 1'b1;
    @(negedge clk);
    check(ss_n == 1'b0, "R2", "flag set -> select low", ss_n, 0);
    sel_flag = 1'b0;
    @(negedge clk);
    check(ss_n == 1'b1, "R2", "flag clear -> select high", ss_n, 1);
    cfg_cpha = 1'b0; sel_flag = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(ss_n == 1'b1, "R1", "phase0 ignores flag", ss_n, 1);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; tx_word = '0; div_val = 16'd1;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_wide = 1'b0;
    sel_flag = 1'b0; miso = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0_byte_msb();
    t_mode0_word_lsb_cpol1();
    t_mode1_back_to_back();
    t_mode1_byte_lsb_div0();
    t_mode0_gap_start();
    t_flag_follow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule